// File: doc/BRIEF.md
# Dual-Clock FIFO with Fall-Through

This block moves words from a producer running on one clock to a consumer running on another clock, where the two clocks have no fixed phase or frequency relation. The write side pushes words into an inferred two-port storage array. The read side takes them out in the same order. Each side keeps its own binary pointer and passes a Gray-coded copy to the other side through a two-flop synchronizer. Every status flag is computed only from registers of the domain that uses it, so both its assertion and its release are timed by that domain's clock.

The parameter `FALL_THROUGH` picks the read interface. When it is 0 (standard mode), the consumer raises `rd_en` and the word comes out one read clock later, marked by `rd_valid`. When it is 1 (fall-through mode), the oldest word is loaded into the output register as soon as it has crossed into the read domain. `rd_valid` then marks a word that is already present, and `rd_en` acknowledges that word. This mode adds one word of capacity, because the output register holds a word as well as the storage array.

Top module: `dc_fifo`

## Requirements
- R1: While either reset is low, `full` and `almost_full` are 0, `empty` and `almost_empty` are 1, and `rd_valid` is 0.
- R2: Words leave the block in the order in which they were accepted, in both read modes.
- R3: Write-side occupancy is the number of words held in the storage array. `full` is 1 when this occupancy equals DEPTH (2**AW, default 16). A write while `full` is 1 is dropped and does not overwrite any stored word.
- R4: In standard mode, `rd_en` while `empty` is 1 is ignored. `rd_valid` stays 0, and the next word written is the next word read.
- R5: `almost_full` is 1 exactly when the write-side occupancy is at least AF_LEVEL (default 12).
- R6: Read-side occupancy is the number of words held in the storage array plus the word in the output register in fall-through mode. `almost_empty` is 1 exactly when this occupancy is at most AE_LEVEL (default 2). `empty` is 1 when the read-side occupancy is zero.
- R7: In standard mode, a `rd_en` accepted at a read clock edge gives `rd_valid` = 1 with the word on `rd_data` after that edge. `rd_valid` returns to 0 after the next edge unless another read is accepted there.
- R8: In fall-through mode, a word written into an empty FIFO appears on `rd_data` with `rd_valid` = 1 and `empty` = 0, without any `rd_en`. `rd_en` while `rd_valid` is 1 consumes that word. While `rd_en` is low, the presented word holds.
- R9: In fall-through mode, the block holds DEPTH+1 words: DEPTH in storage and one in the output register. `full` reports only on the storage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| wrst_n | input | 1 | Asynchronous active-low reset, write domain |
| wr_en | input | 1 | Write request |
| wr_data | input | DW | Word to write |
| full | output | 1 | Storage full (write clock) |
| almost_full | output | 1 | Occupancy at or above AF_LEVEL (write clock) |
| rclk | input | 1 | Read clock |
| rrst_n | input | 1 | Asynchronous active-low reset, read domain |
| rd_en | input | 1 | Read request (standard) or acknowledge (fall-through) |
| rd_data | output | DW | Output word |
| rd_valid | output | 1 | `rd_data` holds a valid word |
| empty | output | 1 | No word available (read clock) |
| almost_empty | output | 1 | Occupancy at or below AE_LEVEL (read clock) |

## Verification
On every cycle, the assertions check these properties:
- Each Gray pointer changes by at most one bit.
- A blocked write leaves the write pointer unchanged.
- A standard-mode read on empty produces no valid word and leaves the read pointer unchanged.
- `full` implies `almost_full`.
- A fall-through word that is not acknowledged stays put.

Only the bench scenarios can show the following, because each needs a word followed end to end or a count held over many operations:
- ordering across many fill and drain patterns;
- the exact flag levels at each occupancy;
- the dropped word when the FIFO is full;
- the extra word of capacity in fall-through mode;
- a word presented without any request.

// File: rtl/dc_fifo.sv
module dc_fifo #(
  parameter int DW           = 8,
  parameter int AW           = 4,
  parameter int AF_LEVEL     = 12,
  parameter int AE_LEVEL     = 2,
  parameter bit FALL_THROUGH = 1'b0
) (
  input  logic          wclk,
  input  logic          wrst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic          full,
  output logic          almost_full,
  input  logic          rclk,
  input  logic          rrst_n,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic          empty,
  output logic          almost_empty
);
  localparam int DEPTH = 1 << AW;
  localparam int PW    = AW + 1;

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wbin, wgray, rbin, rgray;
  logic [PW-1:0] rq1, rq2, wq1, wq2;
  logic [PW-1:0] wcount, stored;
  logic [PW:0]   rcount;
  logic          wr_ok, take, mem_empty;

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // write domain
  assign full        = (wgray == {~rq2[PW-1:PW-2], rq2[PW-3:0]});
  assign wr_ok       = wr_en && !full;
  assign wcount      = wbin - g2b(rq2);
  assign almost_full = (wcount >= PW'(AF_LEVEL));

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      wbin  <= '0;
      wgray <= '0;
      rq1   <= '0;
      rq2   <= '0;
    end else begin
      rq1 <= rgray;
      rq2 <= rq1;
      if (wr_ok) begin
        wbin  <= wbin + 1'b1;
        wgray <= (wbin + 1'b1) ^ ((wbin + 1'b1) >> 1);
      end
    end
  end

  always_ff @(posedge wclk) begin
    if (wr_ok) mem[wbin[AW-1:0]] <= wr_data;
  end

  // read domain
  assign mem_empty    = (rgray == wq2);
  assign stored       = g2b(wq2) - rbin;
  assign almost_empty = (rcount <= (PW+1)'(AE_LEVEL));

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      rbin  <= '0;
      rgray <= '0;
      wq1   <= '0;
      wq2   <= '0;
    end else begin
      wq1 <= wgray;
      wq2 <= wq1;
      if (take) begin
        rbin  <= rbin + 1'b1;
        rgray <= (rbin + 1'b1) ^ ((rbin + 1'b1) >> 1);
      end
    end
  end

  generate
    if (FALL_THROUGH) begin : g_ft
      assign take   = !mem_empty && (!rd_valid || rd_en);
      assign empty  = !rd_valid;
      assign rcount = {1'b0, stored} + (PW+1)'(rd_valid);

      always_ff @(posedge rclk or negedge rrst_n) begin
        if (!rrst_n) begin
          rd_valid <= 1'b0;
          rd_data  <= '0;
        end else if (take) begin
          rd_valid <= 1'b1;
          rd_data  <= mem[rbin[AW-1:0]];
        end else if (rd_en) begin
          rd_valid <= 1'b0;
        end
      end

      AST_FT_HOLD: assert property (@(posedge rclk) disable iff (!rrst_n)
        (rd_valid && !rd_en) |=> (rd_valid && $stable(rd_data))); // R8
    end else begin : g_std
      assign take   = rd_en && !mem_empty;
      assign empty  = mem_empty;
      assign rcount = {1'b0, stored};

      always_ff @(posedge rclk or negedge rrst_n) begin
        if (!rrst_n) begin
          rd_valid <= 1'b0;
          rd_data  <= '0;
        end else begin
          rd_valid <= take;
          if (take) rd_data <= mem[rbin[AW-1:0]];
        end
      end

      AST_NO_READ_ON_EMPTY: assert property (@(posedge rclk) disable iff (!rrst_n)
        (rd_en && empty) |=> (!rd_valid && $stable(rbin))); // R4
      AST_EMPTY_ALSO_LOW: assert property (@(posedge rclk) disable iff (!rrst_n)
        empty |-> almost_empty); // R6
    end
  endgenerate

  AST_NO_OVERFLOW: assert property (@(posedge wclk) disable iff (!wrst_n)
    (wr_en && full) |=> $stable(wbin)); // R3
  AST_WGRAY_STEP: assert property (@(posedge wclk) disable iff (!wrst_n)
    $countones(wgray ^ $past(wgray)) <= 1); // R2
  AST_RGRAY_STEP: assert property (@(posedge rclk) disable iff (!rrst_n)
    $countones(rgray ^ $past(rgray)) <= 1); // R2
  AST_FULL_ALSO_HIGH: assert property (@(posedge wclk) disable iff (!wrst_n)
    full |-> almost_full); // R5
endmodule

// File: tb/tb_dc_fifo.sv
module tb_dc_fifo;
  localparam int DW = 8;
  localparam int DEPTH = 16;
  localparam int AFL = 12;
  localparam int AEL = 2;

  logic wclk = 1'b0, rclk = 1'b0;
  logic wrst_n = 1'b0, rrst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic rd_en_s = 1'b0, rd_en_f = 1'b0;
  logic full_s, afull_s, valid_s, empty_s, aempty_s;
  logic full_f, afull_f, valid_f, empty_f, aempty_f;
  logic [DW-1:0] data_s, data_f;

  always #2.5 wclk = ~wclk;
  always #3.5 rclk = ~rclk;

  dc_fifo #(.DW(DW), .AW(4), .AF_LEVEL(AFL), .AE_LEVEL(AEL), .FALL_THROUGH(1'b0)) dut (
    .wclk(wclk), .wrst_n(wrst_n), .wr_en(wr_en), .wr_data(wr_data),
    .full(full_s), .almost_full(afull_s),
    .rclk(rclk), .rrst_n(rrst_n), .rd_en(rd_en_s), .rd_data(data_s),
    .rd_valid(valid_s), .empty(empty_s), .almost_empty(aempty_s));

  dc_fifo #(.DW(DW), .AW(4), .AF_LEVEL(AFL), .AE_LEVEL(AEL), .FALL_THROUGH(1'b1)) dut_ft (
    .wclk(wclk), .wrst_n(wrst_n), .wr_en(wr_en), .wr_data(wr_data),
    .full(full_f), .almost_full(afull_f),
    .rclk(rclk), .rrst_n(rrst_n), .rd_en(rd_en_f), .rd_data(data_f),
    .rd_valid(valid_f), .empty(empty_f), .almost_empty(aempty_f));

  int checks = 0, failures = 0;
  bit done = 1'b0;
  int q_s[$];
  int q_f[$];
  logic [DW-1:0] nv = 8'h10;

  localparam logic [15:0] VEC [7] = '{
    {8'd3, 8'd1}, {8'd5, 8'd6}, {8'd10, 8'd0}, {8'd2, 8'd4},
    {8'd4, 8'd9}, {8'd1, 8'd1}, {8'd0, 8'd3}};

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic push();
    @(negedge wclk);
    wr_en = 1'b1;
    wr_data = nv;
    if (q_s.size() < DEPTH) q_s.push_back(int'(nv));
    if (q_f.size() < DEPTH + 1) q_f.push_back(int'(nv));
    nv = nv + 1'b1;
    @(negedge wclk);
    wr_en = 1'b0;
  endtask

  task automatic pop_s();
    int e;
    e = q_s.pop_front();
    @(negedge rclk);
    rd_en_s = 1'b1;
    @(negedge rclk);
    rd_en_s = 1'b0;
    chk("R7 std rd_valid after read", int'(valid_s), 1);
    chk("R2 std order", int'(data_s), e);
    @(negedge rclk);
    chk("R7 std rd_valid drops", int'(valid_s), 0);
  endtask

  task automatic pop_f();
    int e;
    e = q_f.pop_front();
    @(negedge rclk);
    chk("R8 ft word presented", int'(valid_f), 1);
    chk("R2 ft order", int'(data_f), e);
    rd_en_f = 1'b1;
    @(negedge rclk);
    rd_en_f = 1'b0;
  endtask

  task automatic settle();
    repeat (6) @(negedge rclk);
    repeat (6) @(negedge wclk);
  endtask

  task automatic check_flags(input string ph);
    int ws;
    ws = (q_f.size() > 0) ? q_f.size() - 1 : 0;
    @(negedge wclk);
    chk({"R3 full std ", ph}, int'(full_s), int'(q_s.size() == DEPTH));
    chk({"R5 almost_full std ", ph}, int'(afull_s), int'(q_s.size() >= AFL));
    chk({"R9 full ft ", ph}, int'(full_f), int'(ws == DEPTH));
    chk({"R5 almost_full ft ", ph}, int'(afull_f), int'(ws >= AFL));
    @(negedge rclk);
    chk({"R6 empty std ", ph}, int'(empty_s), int'(q_s.size() == 0));
    chk({"R6 almost_empty std ", ph}, int'(aempty_s), int'(q_s.size() <= AEL));
    chk({"R6 empty ft ", ph}, int'(empty_f), int'(q_f.size() == 0));
    chk({"R6 almost_empty ft ", ph}, int'(aempty_f), int'(q_f.size() <= AEL));
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge wclk);
    chk("R1 reset full", int'(full_s | full_f), 0);
    chk("R1 reset almost_full", int'(afull_s | afull_f), 0);
    chk("R1 reset empty", int'(empty_s & empty_f), 1);
    chk("R1 reset almost_empty", int'(aempty_s & aempty_f), 1);
    chk("R1 reset rd_valid", int'(valid_s | valid_f), 0);
    wrst_n = 1'b1;
    rrst_n = 1'b1;
    settle();

    for (int v = 0; v < 7; v++) begin
      for (int i = 0; i < int'(VEC[v][15:8]); i++) push();
      settle();
      check_flags($sformatf("after writes %0d", v));
      for (int i = 0; i < int'(VEC[v][7:0]); i++) begin
        if (q_s.size() > 0) pop_s();
        if (q_f.size() > 0) pop_f();
      end
      settle();
      check_flags($sformatf("after reads %0d", v));
    end
    while (q_s.size() > 0) pop_s();
    while (q_f.size() > 0) pop_f();
    settle();
    check_flags("drained");

    // R4: reads on empty ignored, R8: no presentation while empty
    @(negedge rclk);
    rd_en_s = 1'b1;
    rd_en_f = 1'b1;
    repeat (3) begin
      @(negedge rclk);
      chk("R4 std no valid on empty read", int'(valid_s), 0);
      chk("R8 ft no valid while empty", int'(valid_f), 0);
    end
    rd_en_s = 1'b0;
    rd_en_f = 1'b0;
    push();
    settle();
    chk("R8 ft presented without rd_en", int'(valid_f), 1);
    chk("R8 ft empty low", int'(empty_f), 0);
    chk("R8 ft data", int'(data_f), q_f[0]);
    repeat (4) @(negedge rclk);
    chk("R8 ft word holds", int'(data_f), q_f[0]);
    chk("R4 std rd_valid idle", int'(valid_s), 0);
    pop_s();
    pop_f();
    settle();

    // R3 / R9: fill to capacity, overflow dropped
    push();
    settle();
    for (int i = 0; i < DEPTH; i++) push();
    settle();
    check_flags("filled");
    chk("R9 ft holds DEPTH+1", q_f.size(), DEPTH + 1);
    push();
    settle();
    check_flags("overflow");
    chk("R3 std kept DEPTH", q_s.size(), DEPTH);
    while (q_s.size() > 0) pop_s();
    while (q_f.size() > 0) pop_f();
    settle();
    check_flags("final");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule